// File: doc/BRIEF.md
# Thermal Throttle Assertion Timer

This block watches an active-low thermal-throttle signal that comes from outside the chip. It adds up the total time the signal is held low, over any number of separate events. When that running total passes a limit set by the host, the block raises an alert. The alert can also be set to fire on the very first low pulse. A separate boost option forces every fan PWM channel to full duty for as long as the throttle signal is held low. This gives fail-safe cooling without waiting for software.

The host writes the enable, boost, mask and limit fields. It reads the accumulated time at whatever interval it chooses. Comparing readings taken across those intervals shows whether throttling is getting more frequent. A single read-and-clear strobe empties the accumulator and the alert together.

Timing works as follows:
- A free-running tick drives time measurement.
- A prescaler divides that tick by `PRESCALE`, and each division adds one count.
- The 8-bit limit is compared against the top eight bits of the accumulator. One limit step therefore equals `2**(ACC_W-8)` counts.

Top module: `therm_accum_timer`

## Requirements
- R1: Throttle time is counted only while `cfg_enable` is 1. With `cfg_enable` at 0, a low input leaves `acc_value` and `boost_out` unchanged.
- R2: With `cfg_boost` at 1, `boost_out` is 1 while the synchronized input is low and monitoring is enabled. With `cfg_boost` at 0, `boost_out` stays 0.
- R3: While `cfg_mask` is 1, `alert_out` never rises.
- R4: With `cfg_limit` equal to 0 and the mask clear, the first enabled low sample sets `alert_out`.
- R5: With a nonzero limit and the mask clear, `alert_out` is set once `acc_value[ACC_W-1:ACC_W-8]` is greater than or equal to `cfg_limit`. Time is summed across separate low events.
- R6: `acc_value` gains one count for every `PRESCALE` ticks (cycles with `tick` at 1) during which the enabled input is low. Cycles with `tick` at 0 add nothing. A partial prescale count carries over into the next low event.
- R7: `acc_value` increases by at most one per cycle. It holds at all ones instead of wrapping.
- R8: A one-cycle `rd_clr` pulse clears `acc_value`, the partial prescale count and `alert_out` at the next clock edge.
- R9: Once set, `alert_out` stays 1 after the input returns high, until `rd_clr` is pulsed.
- R10: After synchronous reset, `acc_value`, `boost_out` and `alert_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_n_async | input | 1 | Active-low throttle input, asynchronous to `clk` |
| tick | input | 1 | Time-base strobe, one cycle wide |
| cfg_enable | input | 1 | Monitoring enable |
| cfg_boost | input | 1 | Full-duty override enable |
| cfg_mask | input | 1 | Alert suppression |
| cfg_limit | input | 8 | Alert limit in steps of `2**(ACC_W-8)` counts; 0 means alert on first assertion |
| rd_clr | input | 1 | Read-and-clear strobe for the accumulator and the alert |
| acc_value | output | ACC_W | Saturating accumulated assertion time |
| boost_out | output | 1 | Forces all fan duty cycles to full scale |
| alert_out | output | 1 | Latched limit-exceeded alert |

## Verification
The hardest situation to reach is a limit crossing assembled from several separate low events. One of those events must end on a partial prescale count, so that the carry decides exactly when the total reaches the limit. The stimulus holds the input low for counted cycles with the tick running continuously. It first leaves the total one step short of the limit and checks that the alert is still quiet. A further short pulse then tips the total over, and the bench checks that the alert has latched. Saturation is reached with one long low hold whose length exceeds the full accumulator span.

// File: rtl/therm_pkg.sv
package therm_pkg;
  localparam int LIM_W = 8;

  typedef struct packed {
    logic             enable;
    logic             boost;
    logic             mask;
    logic [LIM_W-1:0] limit;
  } therm_cfg_t;
endpackage

// File: rtl/therm_sync.sv
module therm_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RESET_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/therm_prescaler.sv
module therm_prescaler #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic count_en,
  input  logic tick,
  output logic inc
);
  localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

  logic [CW-1:0] pcnt;
  logic          step;

  assign step = count_en & tick;
  assign inc  = step & (pcnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt <= '0;
    else if (step)   pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/therm_accum.sv
module therm_accum #(
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [ACC_W-1:0] acc
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                acc <= '0;
    else if (inc && acc != ACC_MAX) acc <= acc + 1'b1;
  end
endmodule

// File: rtl/therm_accum_timer.sv
module therm_accum_timer
  import therm_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int ACC_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             therm_n_async,
  input  logic             tick,
  input  logic             cfg_enable,
  input  logic             cfg_boost,
  input  logic             cfg_mask,
  input  logic [7:0]       cfg_limit,
  input  logic             rd_clr,
  output logic [ACC_W-1:0] acc_value,
  output logic             boost_out,
  output logic             alert_out
);
  localparam int LIM_LSB = ACC_W - LIM_W;

  therm_cfg_t       cfg;
  logic             therm_n_s;
  logic             asserted;
  logic             inc;
  logic [LIM_W-1:0] acc_upper;
  logic             hit;

  assign cfg = '{enable: cfg_enable, boost: cfg_boost, mask: cfg_mask, limit: cfg_limit};

  therm_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_async(therm_n_async), .q(therm_n_s)
  );

  assign asserted = cfg.enable & ~therm_n_s;

  therm_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .clr(rd_clr), .count_en(asserted), .tick(tick), .inc(inc)
  );

  therm_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .clr(rd_clr), .inc(inc), .acc(acc_value)
  );

  assign acc_upper = acc_value[ACC_W-1:LIM_LSB];
  assign hit = (cfg.limit == '0) ? asserted : (acc_upper >= cfg.limit);

  always_ff @(posedge clk) begin
    if (rst) boost_out <= 1'b0;
    else     boost_out <= cfg.boost & asserted;
  end

  always_ff @(posedge clk) begin
    if (rst || rd_clr)         alert_out <= 1'b0;
    else if (!cfg.mask && hit) alert_out <= 1'b1;
  end
endmodule

// File: rtl/therm_accum_timer_chk.sv
module therm_accum_timer_chk #(
  parameter int ACC_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_enable,
  input logic             cfg_boost,
  input logic             cfg_mask,
  input logic             rd_clr,
  input logic [ACC_W-1:0] acc_value,
  input logic             boost_out,
  input logic             alert_out
);
  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cfg_enable && !rd_clr) |=> $stable(acc_value)); // R1

  AST_NO_BOOST: assert property (@(posedge clk) disable iff (rst)
    !cfg_boost |=> !boost_out); // R2

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cfg_mask && !alert_out) |=> !alert_out); // R3

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> (acc_value == $past(acc_value)) || (acc_value == $past(acc_value) + 1'b1)); // R7

  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> (acc_value == '0) && !alert_out); // R8

  AST_ALERT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alert_out && !rd_clr) |=> alert_out); // R9
endmodule

bind therm_accum_timer therm_accum_timer_chk #(.ACC_W(ACC_W)) u_chk (.*);

// File: tb/therm_accum_timer_test.sv
module therm_accum_timer_test;
  localparam int ACC_W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic therm_n_async = 1'b1;
  logic tick = 1'b1;
  logic cfg_enable = 1'b0;
  logic cfg_boost = 1'b0;
  logic cfg_mask = 1'b1;
  logic [7:0] cfg_limit = 8'd0;
  logic rd_clr = 1'b0;
  logic [ACC_W-1:0] acc_value;
  logic boost_out;
  logic alert_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string req;
    int    sel;   // 0 acc, 1 boost, 2 alert
    int    exp;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  therm_accum_timer #(.PRESCALE(4), .ACC_W(ACC_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .therm_n_async(therm_n_async), .tick(tick),
    .cfg_enable(cfg_enable), .cfg_boost(cfg_boost), .cfg_mask(cfg_mask),
    .cfg_limit(cfg_limit), .rd_clr(rd_clr), .acc_value(acc_value),
    .boost_out(boost_out), .alert_out(alert_out)
  );

  // monitor: pops expected items and compares away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        act = (it.sel == 0) ? int'(acc_value) : (it.sel == 1) ? int'(boost_out) : int'(alert_out);
        checks++;
        if (act != it.exp) begin
          errors++;
          $display("FAIL %s actual %0d expected %0d", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input string req, input int sel, input int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic hold_low(input int n);
    therm_n_async = 1'b0;
    repeat (n) @(negedge clk);
    therm_n_async = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_clear();
    rd_clr = 1'b1;
    @(negedge clk);
    rd_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_item("R10 acc after reset", 0, 0);
    expect_item("R10 boost after reset", 1, 0);
    expect_item("R10 alert after reset", 2, 0);

    // R6 accumulation with carry across events
    cfg_enable = 1'b1; cfg_mask = 1'b1; cfg_limit = 8'd255;
    hold_low(40);
    expect_item("R6 40 ticks give 10", 0, 10);
    hold_low(6);
    expect_item("R6 carry 46 ticks give 11", 0, 11);
    hold_low(2);
    expect_item("R6 partial carry completes", 0, 12);

    // R6 tick gating
    tick = 1'b0;
    hold_low(40);
    expect_item("R6 no tick no count", 0, 12);
    tick = 1'b1;

    // R1 disabled
    cfg_enable = 1'b0; cfg_boost = 1'b1;
    therm_n_async = 1'b0;
    repeat (5) @(negedge clk);
    expect_item("R1 boost off while disabled", 1, 0);
    therm_n_async = 1'b1;
    repeat (6) @(negedge clk);
    expect_item("R1 acc held while disabled", 0, 12);

    // R2 boost
    cfg_enable = 1'b1;
    therm_n_async = 1'b0;
    repeat (5) @(negedge clk);
    expect_item("R2 boost during assertion", 1, 1);
    therm_n_async = 1'b1;
    repeat (6) @(negedge clk);
    expect_item("R2 boost released", 1, 0);
    cfg_boost = 1'b0;
    therm_n_async = 1'b0;
    repeat (5) @(negedge clk);
    expect_item("R2 boost bit clear", 1, 0);
    therm_n_async = 1'b1;
    repeat (6) @(negedge clk);

    // R8 clear
    pulse_clear();
    expect_item("R8 acc cleared", 0, 0);
    hold_low(3);
    expect_item("R8 partial count cleared", 0, 0);
    pulse_clear();

    // R5 nonzero limit across events (limit 3 = 12 counts = 48 ticks)
    cfg_mask = 1'b0; cfg_limit = 8'd3;
    hold_low(20);
    hold_low(22);
    hold_low(2);
    expect_item("R5 below limit acc", 0, 11);
    expect_item("R5 below limit no alert", 2, 0);
    hold_low(4);
    expect_item("R5 limit reached alert", 2, 1);
    repeat (10) @(negedge clk);
    expect_item("R9 alert stays latched", 2, 1);
    pulse_clear();
    expect_item("R8 alert cleared", 2, 0);

    // R3 mask with zero limit
    cfg_mask = 1'b1; cfg_limit = 8'd0;
    hold_low(10);
    expect_item("R3 masked no alert", 2, 0);

    // R4 zero limit first assertion
    cfg_mask = 1'b0;
    hold_low(1);
    expect_item("R4 alert on first assertion", 2, 1);
    pulse_clear();

    // R7 saturation
    cfg_mask = 1'b1; cfg_limit = 8'd255;
    hold_low(5000);
    expect_item("R7 saturates at max", 0, 1023);
    hold_low(8);
    expect_item("R7 no wrap", 0, 1023);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule